// File: doc/BRIEF.md
# Indexed Effective Address Unit

This block forms the operand address for the indexed addressing family of an 8-bit processor with 16-bit addresses. A caller gives it the postbyte, any trailing offset bytes already assembled into a 16-bit word, the four pointer registers, the two accumulators and the program counter value. The block picks a base, adds the selected offset and applies any auto-increment or auto-decrement. It returns the effective address together with the updated pointer value that the caller should write back.

When the postbyte asks for the indirect form, the block reads a 16-bit pointer from memory through a simple one-cycle-latency read port, high byte first. That pointer becomes the final address. The postbyte decode also gives the caller the number of trailing offset bytes it must fetch, and the block flags postbyte encodings that have no meaning.

Fetching the postbyte and the offset bytes, and the final operand access, belong to the caller.

Top module: `idx_ea_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done`, `busy`, `rd_req`, `wb_en` and `illegal` are 0.
- R2: With postbyte bit 7 = 0, the address is the selected register plus the sign-extended 5-bit field in bits 4..0. Bits 6..5 select the register (00 X, 01 Y, 10 U, 11 S) in every register-based mode. No write-back takes place.
- R3: Mode codes 0 and 1 (bit 7 = 1, low nibble) give the old register value as the address and report a write-back of that register plus 1 or plus 2 on `wb_val`, with `wb_sel` naming it.
- R4: Mode codes 2 and 3 decrease the register by 1 or by 2 first. The decreased value is both the address and the write-back value.
- R5: Mode 4 adds zero. Modes 5 and 6 add the sign-extended B and A accumulator. Mode 0xB adds the 16-bit D value, which is {A, B} with A as the high byte.
- R6: Mode 8 adds the sign-extended low byte of `offset`. Mode 9 adds all 16 bits of `offset`.
- R7: Modes 0xC and 0xD add the sign-extended low byte, or all 16 bits, of `offset` to `pc`. Bits 6..5 are ignored.
- R8: With bit 7 = 1 and bit 4 = 1, the computed address is not returned. The block reads bytes at that address and at the address plus 1, and returns {first byte, second byte} as `ea`, 4 cycles after the accepted start. Any write-back from mode 1 or 3 is reported with that result.
- R9: Mode 0xF with bit 4 = 1 uses all 16 bits of `offset` as the pointer address.
- R10: Mode codes 7, 0xA and 0xE, mode 0xF without bit 4, and bit 4 with mode 0 or 2 return `done` with `illegal` = 1. In that case `wb_en` = 0 and no read is issued.
- R11: All address and write-back arithmetic wraps modulo 2^16.
- R12: A start accepted while `busy` is low in a mode without the indirect read gives `done` in the next cycle. A start while `busy` is high is ignored.
- R13: `extra_bytes` is a combinational decode of `postbyte`. It is 1 for modes 8 and 0xC, 2 for modes 9, 0xD and legal 0xF, and 0 otherwise, including for illegal encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an address computation with the current inputs |
| postbyte | input | 8 | Indexed mode postbyte |
| offset | input | 16 | Trailing offset bytes, high byte first in bits 15..8 |
| reg_x | input | 16 | Pointer register X |
| reg_y | input | 16 | Pointer register Y |
| reg_u | input | 16 | Pointer register U |
| reg_s | input | 16 | Pointer register S |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc | input | 16 | Program counter value used for PC-relative modes |
| extra_bytes | output | 2 | Number of trailing offset bytes the postbyte needs |
| busy | output | 1 | Indirect pointer read in progress |
| rd_req | output | 1 | Memory read request, data expected one cycle later |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Memory read data |
| done | output | 1 | One-cycle strobe: result valid |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Postbyte encoding is illegal (valid with `done`) |
| wb_en | output | 1 | Base register write-back requested (valid with `done`) |
| wb_sel | output | 2 | Register to write back: 0 X, 1 Y, 2 U, 3 S |
| wb_val | output | 16 | Value to write back |

## Verification
Random postbytes cover every mode code, both values of the indirect bit and all four register selects. This separates correct base selection and offset handling from swaps of A and B, missing sign extension and a wrong increment or decrement order. Directed cases place pointers and the program counter next to 0x0000 and 0xFFFF to expose carries that do not wrap. Accumulator values with bit 7 set tell signed from unsigned addition. A start pulsed during an indirect read shows whether the busy guard holds. Indirect results are compared with a pointer rebuilt from a fixed memory pattern, which exposes a reversed byte order or an off-by-one second address.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int EA_W  = 16;
  localparam int ACC_W = 8;
  localparam int NREG  = 4;
  localparam int RSEL_W = $clog2(NREG);

  typedef enum logic [2:0] {
    OFS_NONE, OFS_C5, OFS_A, OFS_B, OFS_D, OFS_8, OFS_16
  } ofs_kind_e;

  typedef enum logic [1:0] {
    STEP_NONE, STEP_POST, STEP_PRE
  } step_kind_e;

  typedef struct packed {
    logic [RSEL_W-1:0] rsel;
    logic              base_pc;
    logic              base_zero;
    ofs_kind_e         ofs;
    logic [4:0]        c5;
    step_kind_e        step;
    logic              step_two;
    logic              indirect;
    logic              illegal;
    logic [1:0]        xbytes;
  } idx_dec_t;
endpackage

// File: rtl/idx_postbyte_decode.sv
module idx_postbyte_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] postbyte,
  output idx_dec_t   dec
);
  always_comb begin
    dec           = '0;
    dec.rsel      = postbyte[6:5];
    dec.c5        = postbyte[4:0];
    dec.ofs       = OFS_NONE;
    dec.step      = STEP_NONE;
    if (!postbyte[7]) begin
      dec.ofs = OFS_C5;
    end else begin
      dec.indirect = postbyte[4];
      unique case (postbyte[3:0])
        4'h0: begin dec.step = STEP_POST; dec.illegal = postbyte[4]; end
        4'h1: begin dec.step = STEP_POST; dec.step_two = 1'b1; end
        4'h2: begin dec.step = STEP_PRE;  dec.illegal = postbyte[4]; end
        4'h3: begin dec.step = STEP_PRE;  dec.step_two = 1'b1; end
        4'h4: dec.ofs = OFS_NONE;
        4'h5: dec.ofs = OFS_B;
        4'h6: dec.ofs = OFS_A;
        4'h8: begin dec.ofs = OFS_8;  dec.xbytes = 2'd1; end
        4'h9: begin dec.ofs = OFS_16; dec.xbytes = 2'd2; end
        4'hB: dec.ofs = OFS_D;
        4'hC: begin dec.ofs = OFS_8;  dec.base_pc = 1'b1; dec.xbytes = 2'd1; end
        4'hD: begin dec.ofs = OFS_16; dec.base_pc = 1'b1; dec.xbytes = 2'd2; end
        4'hF: begin
          dec.ofs       = OFS_16;
          dec.base_zero = 1'b1;
          dec.xbytes    = 2'd2;
          dec.illegal   = !postbyte[4];
        end
        default: dec.illegal = 1'b1;
      endcase
    end
    if (dec.illegal) begin
      dec.indirect = 1'b0;
      dec.step     = STEP_NONE;
      dec.xbytes   = 2'd0;
      dec.ofs      = OFS_NONE;
    end
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
(
  input  idx_dec_t                   dec,
  input  logic [NREG-1:0][EA_W-1:0]  regs,
  input  logic [ACC_W-1:0]           acc_a,
  input  logic [ACC_W-1:0]           acc_b,
  input  logic [EA_W-1:0]            pc,
  input  logic [EA_W-1:0]            offset,
  output logic [EA_W-1:0]            ea_pre,
  output logic [EA_W-1:0]            wb_val
);
  logic [EA_W-1:0] base, ofs_val, step_amt;

  always_comb begin
    if (dec.base_zero)    base = '0;
    else if (dec.base_pc) base = pc;
    else                  base = regs[dec.rsel];
  end

  always_comb begin
    unique case (dec.ofs)
      OFS_C5:  ofs_val = EA_W'($signed(dec.c5));
      OFS_A:   ofs_val = EA_W'($signed(acc_a));
      OFS_B:   ofs_val = EA_W'($signed(acc_b));
      OFS_D:   ofs_val = EA_W'({acc_a, acc_b});
      OFS_8:   ofs_val = EA_W'($signed(offset[ACC_W-1:0]));
      OFS_16:  ofs_val = offset;
      default: ofs_val = '0;
    endcase
  end

  assign step_amt = dec.step_two ? EA_W'(2) : EA_W'(1);

  always_comb begin
    unique case (dec.step)
      STEP_POST: begin ea_pre = base;            wb_val = base + step_amt; end
      STEP_PRE:  begin wb_val = base - step_amt; ea_pre = base - step_amt; end
      default:   begin ea_pre = base + ofs_val;  wb_val = base;            end
    endcase
  end
endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch
  import idx_ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [EA_W-1:0]  ptr_addr,
  input  logic [ACC_W-1:0] rd_data,
  output logic             busy,
  output logic             rd_req,
  output logic [EA_W-1:0]  rd_addr,
  output logic             ptr_ready,
  output logic [EA_W-1:0]  ptr
);
  typedef enum logic [1:0] {PF_IDLE, PF_HI, PF_LO, PF_FIN} pf_st_e;
  pf_st_e st;
  logic [ACC_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PF_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      hi_q    <= '0;
    end else begin
      unique case (st)
        PF_IDLE: if (go) begin
          rd_req  <= 1'b1;
          rd_addr <= ptr_addr;
          st      <= PF_HI;
        end
        PF_HI: begin
          rd_addr <= rd_addr + EA_W'(1);
          st      <= PF_LO;
        end
        PF_LO: begin
          hi_q   <= rd_data;
          rd_req <= 1'b0;
          st     <= PF_FIN;
        end
        default: st <= PF_IDLE;
      endcase
    end
  end

  assign busy      = (st != PF_IDLE);
  assign ptr_ready = (st == PF_FIN);
  assign ptr       = {hi_q, rd_data};

  AST_RD_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |=> rd_req && (rd_addr == $past(rd_addr) + EA_W'(1))); // R8
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  postbyte,
  input  logic [15:0] offset,
  input  logic [15:0] reg_x,
  input  logic [15:0] reg_y,
  input  logic [15:0] reg_u,
  input  logic [15:0] reg_s,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  acc_b,
  input  logic [15:0] pc,
  output logic [1:0]  extra_bytes,
  output logic        busy,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        done,
  output logic [15:0] ea,
  output logic        illegal,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_val
);
  idx_dec_t                  dec;
  logic [NREG-1:0][EA_W-1:0] regs;
  logic [EA_W-1:0]           ea_pre, wb_calc, ptr;
  logic                      accept, ptr_ready;
  logic                      pend_wb, ind_q;
  logic [RSEL_W-1:0]         pend_sel;
  logic [EA_W-1:0]           pend_val;

  assign regs   = {reg_s, reg_u, reg_y, reg_x};
  assign accept = start && !busy;

  idx_postbyte_decode dec_i (.postbyte(postbyte), .dec(dec));

  idx_ea_calc calc_i (
    .dec(dec), .regs(regs), .acc_a(acc_a), .acc_b(acc_b), .pc(pc),
    .offset(offset), .ea_pre(ea_pre), .wb_val(wb_calc)
  );

  idx_ptr_fetch fetch_i (
    .clk(clk), .rst(rst), .go(accept && dec.indirect), .ptr_addr(ea_pre),
    .rd_data(rd_data), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .ptr_ready(ptr_ready), .ptr(ptr)
  );

  assign extra_bytes = dec.xbytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      ea       <= '0;
      illegal  <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
      pend_wb  <= 1'b0;
      pend_sel <= '0;
      pend_val <= '0;
      ind_q    <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      wb_en   <= 1'b0;
      if (accept) begin
        ind_q    <= dec.indirect;
        pend_wb  <= (dec.step != STEP_NONE);
        pend_sel <= dec.rsel;
        pend_val <= wb_calc;
        if (!dec.indirect) begin
          done    <= 1'b1;
          ea      <= ea_pre;
          illegal <= dec.illegal;
          wb_en   <= (dec.step != STEP_NONE);
          wb_sel  <= dec.rsel;
          wb_val  <= wb_calc;
        end
      end else if (ptr_ready) begin
        done   <= 1'b1;
        ea     <= ptr;
        wb_en  <= pend_wb;
        wb_sel <= pend_sel;
        wb_val <= pend_val;
      end
    end
  end

  AST_ILL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    done && illegal |-> !wb_en); // R10
  AST_ILL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    accept && dec.illegal |=> !rd_req); // R10
  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    accept && !dec.indirect |=> done); // R12
  AST_READ_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(accept)); // R12
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    done && wb_en && !ind_q |->
      (ea == wb_val) || (wb_val - ea == 16'd1) || (wb_val - ea == 16'd2)); // R3
endmodule

// File: tb/idx_ea_unit_tb_top.sv
`timescale 1ns/1ps
module idx_ea_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] postbyte = '0, acc_a = '0, acc_b = '0, rd_data;
  logic [15:0] offset = '0, reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, pc = '0;
  logic [1:0] extra_bytes, wb_sel;
  logic busy, rd_req, done, illegal, wb_en;
  logic [15:0] rd_addr, ea, wb_val;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  idx_ea_unit dut_i (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

  typedef struct packed {
    logic ill; logic ind; logic wb; logic [1:0] sel;
    logic [15:0] wval; logic [15:0] ea; logic [1:0] xb;
  } exp_t;

  function automatic exp_t model(input logic [7:0] pb, input logic [15:0] off,
      input logic [15:0] x, y, u, s, input logic [7:0] a, b, input logic [15:0] p);
    exp_t e; logic [15:0] r;
    e = '0;
    case (pb[6:5]) 2'd0: r = x; 2'd1: r = y; 2'd2: r = u; default: r = s; endcase
    e.sel = pb[6:5];
    if (!pb[7]) e.ea = r + {{11{pb[4]}}, pb[4:0]};
    else begin
      case (pb[3:0])
        4'h0: if (pb[4]) e.ill = 1; else begin e.ea = r; e.wb = 1; e.wval = r + 1; end
        4'h1: begin e.ea = r; e.wb = 1; e.wval = r + 2; end
        4'h2: if (pb[4]) e.ill = 1; else begin e.wval = r - 1; e.ea = e.wval; e.wb = 1; end
        4'h3: begin e.wval = r - 2; e.ea = e.wval; e.wb = 1; end
        4'h4: e.ea = r;
        4'h5: e.ea = r + {{8{b[7]}}, b};
        4'h6: e.ea = r + {{8{a[7]}}, a};
        4'h8: begin e.ea = r + {{8{off[7]}}, off[7:0]}; e.xb = 1; end
        4'h9: begin e.ea = r + off; e.xb = 2; end
        4'hB: e.ea = r + {a, b};
        4'hC: begin e.ea = p + {{8{off[7]}}, off[7:0]}; e.xb = 1; end
        4'hD: begin e.ea = p + off; e.xb = 2; end
        4'hF: if (!pb[4]) e.ill = 1; else begin e.ea = off; e.xb = 2; end
        default: e.ill = 1;
      endcase
      e.ind = pb[4] && !e.ill;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [7:0] pb, input exp_t e);
    if (e.ill) return "R10";
    if (!pb[7]) return "R2";
    case (pb[3:0])
      4'h0, 4'h1: return "R3";
      4'h2, 4'h3: return "R4";
      4'h8, 4'h9: return "R6";
      4'hC, 4'hD: return "R7";
      4'hF: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag_ovr, input logic [7:0] pb, input logic [15:0] off,
      input logic [15:0] x, y, u, s, input logic [7:0] a, b, input logic [15:0] p);
    exp_t e; int lat; logic seen_rd; string tg; logic [15:0] exp_ea;
    e = model(pb, off, x, y, u, s, a, b, p);
    tg = (tag_ovr != "") ? tag_ovr : tag_of(pb, e);
    exp_ea = e.ind ? {memf(e.ea), memf(e.ea + 16'd1)} : e.ea;
    @(negedge clk);
    postbyte = pb; offset = off; reg_x = x; reg_y = y; reg_u = u; reg_s = s;
    acc_a = a; acc_b = b; pc = p; start = 1'b1;
    #1;
    chk("R13", "extra_bytes", extra_bytes, e.xb);
    @(negedge clk);
    start = 1'b0;
    lat = 1; seen_rd = 1'b0;
    while (lat < 8) begin
      if (rd_req) seen_rd = 1'b1;
      if (done) break;
      @(negedge clk);
      lat++;
    end
    chk(e.ind ? "R8" : "R12", "latency", lat, e.ind ? 4 : 1);
    chk(e.ill ? "R10" : tg, "illegal", illegal, e.ill);
    chk(e.ind ? "R10_R8" : "R10", "read issued", seen_rd, e.ind);
    chk(e.ind ? (pb[3:0] == 4'hF ? "R9" : "R8") : tg, "ea", e.ill ? 32'(e.ill) : ea,
        e.ill ? 32'(e.ill) : exp_ea);
    chk(tg, "wb_en", wb_en, e.wb);
    if (e.wb) begin
      chk(tg, "wb_sel", wb_sel, e.sel);
      chk(tg, "wb_val", wb_val, e.wval);
    end
  endtask

  task automatic busy_ignore();
    int dones; logic [15:0] exp_ea;
    exp_ea = {memf(16'h1234), memf(16'h1235)};
    @(negedge clk);
    postbyte = 8'h94; reg_x = 16'h1234; start = 1'b1;
    @(negedge clk);
    postbyte = 8'h84; reg_x = 16'h4000; dones = 0;
    chk("R12", "busy while reading", busy, 1'b1);
    for (int i = 0; i < 8; i++) begin
      if (i == 1) start = 1'b0;
      if (done) begin
        dones++;
        chk("R12", "ea after busy start", ea, exp_ea);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R12", "done count", dones, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_1DEA));
    repeat (4) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "busy in reset", busy, 0);
    rst = 1'b0;
    #1;
    chk("R1", "done", done, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "rd_req", rd_req, 0);
    chk("R1", "wb_en", wb_en, 0);
    chk("R1", "illegal", illegal, 0);
    // directed corner cases
    run_op("R2",  8'h3F, 16'h0, 16'h0, 16'h2000, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R11", 8'h81, 16'h0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R11", 8'hE3, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0001, 8'h0, 8'h0, 16'h0);
    run_op("R11", 8'h8D, 16'h0020, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'hFFF0);
    run_op("R5",  8'hC6, 16'h0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'h80, 8'h01, 16'h0);
    run_op("R5",  8'hAB, 16'h0, 16'h0, 16'h0100, 16'h0, 16'h0, 8'hFF, 8'hFE, 16'h0);
    run_op("R7",  8'hEC, 16'h0080, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0500);
    run_op("R9",  8'h9F, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R8",  8'hB1, 16'h0, 16'h0, 16'h7FFE, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R10", 8'h90, 16'h0, 16'h1111, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R10", 8'h8F, 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    run_op("R10", 8'h87, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
    busy_ignore();
    // constrained random
    for (int n = 0; n < 600; n++) begin
      run_op("", 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
    end
    repeat (2) @(negedge clk);
    summary();
  end
endmodule